// File: doc/BRIEF.md
# Prioritized interrupt request controller

This block gathers a group of maskable interrupt sources and one non-maskable source. Each source has a request flag that is set by a rising edge on its input and stays set until the CPU acknowledges it or software clears it. Each maskable source also has a 3-bit level that software writes through a small register port. Levels 1 to 6 enable a source. Levels 0 and 7 both block it, and every level comes out of reset at 0.

The request flags and levels feed a combinational arbiter. The arbiter reports the level and the 8-bit vector of the winning request to the CPU. Ordering is by level first. Among requests at the same level, the source with the lowest vector wins. The non-maskable source always reports the top level and the lowest vector. A vector is a byte offset into a 256-byte handler table at the top of memory. The vectors are spaced four bytes apart, so each table entry holds a 32-bit handler address.

When the CPU raises the acknowledge strobe for one cycle, the flag of the current winner is cleared. A new edge that arrives in the same cycle is never lost.

Top module: `irq_arbiter`

## Requirements
- R1: A rising edge on `src_in[i]` sets flag i, and the flag is visible at the outputs after the next clock edge. An input that stays high does not set the flag again after the flag is cleared.
- R2: A write with `cfg_we` stores `cfg_level` for source `cfg_idx`, and the new value is in effect after the edge. All levels reset to 0. A source at level 0 or 7 takes no part in arbitration, but its flag stays latched and becomes visible once an enabling level (1 to 6) is written.
- R3: `req_level` equals the highest level among the pending enabled requests. It is 0 when there is none, including directly after reset.
- R4: When several pending requests share the highest level, the one with the lowest vector (lowest source index) wins.
- R5: The non-maskable vector is `VEC_BASE`. Maskable source i has vector `VEC_BASE + 4*(i+1)`, so the two low bits of every vector are 0.
- R6: A pending non-maskable request presents level 7 and vector `VEC_BASE`, whatever the level registers hold. It beats every maskable request and is not affected by `clr_mask`.
- R7: `ack` clears only the flag of the current winner. When nothing is pending, `ack` has no effect.
- R8: A rising edge that arrives in the same cycle as an `ack` is kept, whether it belongs to a different source or to the winner itself.
- R9: A 1 in bit i of `clr_mask` clears maskable flag i at the edge. A rising edge on the same source in the same cycle takes precedence over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_in | input | NSRC | Maskable request inputs, rising-edge sensitive |
| nmi_in | input | 1 | Non-maskable request input, rising-edge sensitive |
| cfg_we | input | 1 | Level write enable |
| cfg_idx | input | IDX_W | Source index for the level write |
| cfg_level | input | LVL_W | Level value to write |
| clr_mask | input | NSRC | Software clear of maskable flags, one bit per source |
| ack | input | 1 | CPU acknowledge strobe |
| req_level | output | LVL_W | Level of the winning request, 0 when idle |
| req_vec | output | 8 | Vector of the winning request |

## Verification
Flags and levels are registers, and the arbiter after them is purely combinational. An edge, a level write, an acknowledge or a clear therefore shows on `req_level` and `req_vec` exactly one clock edge after the cycle in which it was driven. The bench drives every input 1 ns after a rising edge and reads the outputs 1 ns after the following edge, so each check sees the result of exactly one update. A pulse task also holds the input low for one extra cycle, so that the next pulse is always a fresh edge.

// File: rtl/irq_arbiter.sv
`timescale 1ns/1ps
module irq_arbiter #(
  parameter int          NSRC     = 8,
  parameter int          LVL_W    = 3,
  parameter logic [7:0]  VEC_BASE = 8'h20,
  parameter int          VEC_STEP = 4,
  localparam int         IDX_W    = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_in,
  input  logic              nmi_in,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [LVL_W-1:0]  cfg_level,
  input  logic [NSRC-1:0]   clr_mask,
  input  logic              ack,
  output logic [LVL_W-1:0]  req_level,
  output logic [7:0]        req_vec
);
  localparam logic [LVL_W-1:0] LVL_TOP = '1;

  logic [NSRC-1:0]  src_q, pend, rise, ack_clr;
  logic             nmi_q, nmi_pend, nmi_rise;
  logic [LVL_W-1:0] lvl [NSRC];
  logic [LVL_W-1:0] eff [NSRC];
  logic [LVL_W-1:0] best_lvl;
  logic [IDX_W-1:0] best_idx;

  assign rise     = src_in & ~src_q;
  assign nmi_rise = nmi_in & ~nmi_q;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    always_ff @(posedge clk) begin
      if (!rst_n)                                   lvl[i] <= '0;
      else if (cfg_we && cfg_idx == IDX_W'(i))      lvl[i] <= cfg_level;
    end
    assign eff[i] = (pend[i] && lvl[i] != '0 && lvl[i] != LVL_TOP) ? lvl[i] : '0;
  end

  always_comb begin
    best_lvl = '0;
    best_idx = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (eff[i] != '0 && eff[i] >= best_lvl) begin
        best_lvl = eff[i];
        best_idx = IDX_W'(i);
      end
    end
  end

  assign ack_clr   = (ack && !nmi_pend && best_lvl != '0) ? (NSRC'(1) << best_idx) : '0;
  assign req_level = nmi_pend ? LVL_TOP : best_lvl;
  assign req_vec   = nmi_pend ? VEC_BASE
                              : VEC_BASE + 8'(VEC_STEP * (int'(best_idx) + 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q    <= '0;
      nmi_q    <= 1'b0;
      pend     <= '0;
      nmi_pend <= 1'b0;
    end else begin
      src_q    <= src_in;
      nmi_q    <= nmi_in;
      pend     <= (pend & ~ack_clr & ~clr_mask) | rise;
      nmi_pend <= (nmi_pend & ~ack) | nmi_rise;
    end
  end
endmodule

// File: rtl/irq_arbiter_chk.sv
`timescale 1ns/1ps
module irq_arbiter_chk #(
  parameter int         NSRC     = 8,
  parameter int         LVL_W    = 3,
  parameter logic [7:0] VEC_BASE = 8'h20
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NSRC-1:0]  src_in,
  input logic [NSRC-1:0]  src_q,
  input logic             nmi_in,
  input logic             nmi_q,
  input logic [NSRC-1:0]  pend,
  input logic             nmi_pend,
  input logic [NSRC-1:0]  clr_mask,
  input logic             ack,
  input logic [LVL_W-1:0] req_level,
  input logic [7:0]       req_vec
);
  localparam logic [LVL_W-1:0] TOP = '1;

  a_r1_edge_latches: assert property (@(posedge clk) disable iff (!rst_n)
    (|(src_in & ~src_q)) |=> ((pend & $past(src_in & ~src_q)) == $past(src_in & ~src_q)));

  a_r3_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (pend == '0 && !nmi_pend) |-> (req_level == '0));

  a_r5_vec_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    (req_level != '0) |-> (req_vec[1:0] == 2'b00));

  a_r6_nmi_on_top: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_pend |-> (req_level == TOP && req_vec == VEC_BASE));

  a_r6_maskable_below_top: assert property (@(posedge clk) disable iff (!rst_n)
    !nmi_pend |-> (req_level != TOP));

  a_r7_ack_nmi_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && nmi_pend && !(nmi_in && !nmi_q)) |=> !nmi_pend);

  a_r7_ack_clears_one: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !nmi_pend && req_level != '0 && (src_in & ~src_q) == '0 && clr_mask == '0)
      |=> ($countones(pend) == $countones($past(pend)) - 1));

  a_r9_sw_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (|clr_mask) |=> ((pend & $past(clr_mask & ~(src_in & ~src_q))) == '0));
endmodule

bind irq_arbiter irq_arbiter_chk #(.NSRC(NSRC), .LVL_W(LVL_W), .VEC_BASE(VEC_BASE)) u_chk (
  .clk(clk), .rst_n(rst_n), .src_in(src_in), .src_q(src_q), .nmi_in(nmi_in), .nmi_q(nmi_q),
  .pend(pend), .nmi_pend(nmi_pend), .clr_mask(clr_mask), .ack(ack),
  .req_level(req_level), .req_vec(req_vec)
);

// File: tb/tb_irq_arbiter.sv
`timescale 1ns/1ps
module tb_irq_arbiter;
  localparam int N = 8;
  localparam int BASE = 32;

  logic clk = 0, rst_n = 0;
  logic [N-1:0] src_in = '0, clr_mask = '0;
  logic nmi_in = 0, cfg_we = 0, ack = 0;
  logic [2:0] cfg_idx = '0, cfg_level = '0;
  logic [2:0] req_level;
  logic [7:0] req_vec;

  int n_chk = 0, n_fail = 0;
  int lv [N];
  bit done = 0;

  irq_arbiter dut (.clk(clk), .rst_n(rst_n), .src_in(src_in), .nmi_in(nmi_in),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_level(cfg_level), .clr_mask(clr_mask),
    .ack(ack), .req_level(req_level), .req_vec(req_vec));

  always #2 clk = ~clk;

  task automatic step(); @(posedge clk); #1; endtask

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic set_level(int s, int l);
    cfg_we = 1; cfg_idx = 3'(s); cfg_level = 3'(l); step(); cfg_we = 0; lv[s] = l;
  endtask

  task automatic pulse(logic [N-1:0] m);
    src_in = m; step(); src_in = '0; step();
  endtask

  task automatic do_ack(); ack = 1; step(); ack = 0; endtask

  task automatic sw_clr(logic [N-1:0] m); clr_mask = m; step(); clr_mask = '0; endtask

  function automatic void calc(input logic [N-1:0] pm, output int l, output int v, output int w);
    l = 0; v = 0; w = -1;
    for (int i = 0; i < N; i++)
      if (pm[i] && lv[i] >= 1 && lv[i] <= 6 && lv[i] > l) begin
        l = lv[i]; w = i; v = BASE + 4 * (i + 1);
      end
  endfunction

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int el, ev, ew;
    logic [N-1:0] m;
    for (int i = 0; i < N; i++) lv[i] = 0;
    step(); step(); rst_n = 1; step();
    chk("R3 level after reset", req_level, 0);

    // R2 R5 R7 R9: every source at every level
    for (int s = 0; s < N; s++) begin
      for (int l = 0; l < 8; l++) begin
        set_level(s, l);
        pulse(N'(1) << s);
        el = (l == 0 || l == 7) ? 0 : l;
        chk("R2 level gating", req_level, el);
        if (el != 0) begin
          chk("R5 vector of source", req_vec, BASE + 4 * (s + 1));
          do_ack();
          chk("R7 ack clears winner", req_level, 0);
        end else begin
          set_level(s, 3);
          chk("R2 flag held while disabled", req_level, 3);
          sw_clr('1);
          chk("R9 software clear", req_level, 0);
        end
        set_level(s, 0);
      end
    end

    // R3 R4 R7: all pairs
    for (int i = 0; i < N; i++) begin
      for (int j = i + 1; j < N; j++) begin
        set_level(i, 1 + (i * 5 + j) % 6);
        set_level(j, 1 + (j * 5 + i) % 6);
        m = (N'(1) << i) | (N'(1) << j);
        pulse(m);
        calc(m, el, ev, ew);
        chk("R3 pair level", req_level, el);
        chk("R4 pair vector", req_vec, ev);
        do_ack();
        m[ew] = 1'b0;
        calc(m, el, ev, ew);
        chk("R7 remaining level", req_level, el);
        chk("R7 remaining vector", req_vec, ev);
        do_ack();
        chk("R7 pair drained", req_level, 0);
        set_level(i, 0); set_level(j, 0);
      end
    end

    // R4 all at one level
    for (int i = 0; i < N; i++) set_level(i, 4);
    pulse('1);
    for (int k = 0; k < N; k++) begin
      chk("R4 tie order", req_vec, BASE + 4 * (k + 1));
      do_ack();
    end
    chk("R4 tie drained", req_level, 0);
    for (int i = 0; i < N; i++) set_level(i, 0);

    // R6 non-maskable
    set_level(3, 6);
    pulse(8'h08);
    nmi_in = 1; step(); nmi_in = 0; step();
    chk("R6 nmi level", req_level, 7);
    chk("R6 nmi vector", req_vec, BASE);
    sw_clr(8'h00);
    clr_mask = '1; cfg_we = 1; cfg_idx = 3'd3; cfg_level = 3'd0; step();
    clr_mask = '0; cfg_we = 0;
    chk("R6 nmi unaffected by clr and levels", req_level, 7);
    set_level(3, 6);
    pulse(8'h08);
    do_ack();
    chk("R6 maskable after nmi ack", req_level, 6);
    chk("R6 maskable vector after nmi", req_vec, BASE + 16);
    do_ack();
    chk("R6 drained", req_level, 0);

    // R8 edge during ack of another source
    set_level(2, 5); set_level(6, 2);
    pulse(8'h04);
    ack = 1; src_in = 8'h40; step(); ack = 0; src_in = '0; step();
    chk("R8 new edge kept", req_level, 2);
    chk("R8 new edge vector", req_vec, BASE + 28);
    do_ack();
    set_level(1, 4);
    pulse(8'h02);
    ack = 1; src_in = 8'h02; step(); ack = 0; src_in = '0; step();
    chk("R8 same source edge kept", req_level, 4);
    do_ack();
    chk("R8 drained", req_level, 0);

    // R1 steady high does not relatch
    src_in = 8'h02; step(); step();
    chk("R1 edge latched", req_level, 4);
    do_ack(); step();
    chk("R1 held input no relatch", req_level, 0);
    src_in = '0; step();

    // R9 clear loses to simultaneous edge
    clr_mask = 8'h02; src_in = 8'h02; step(); clr_mask = '0; src_in = '0; step();
    chk("R9 edge beats clear", req_level, 4);
    do_ack();

    // R7 ack while idle
    do_ack();
    chk("R7 idle ack no effect", req_level, 0);
    pulse(8'h02);
    chk("R7 request after idle ack", req_level, 4);
    do_ack();

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule